// File: doc/BRIEF.md
# Extend, Negate and Decrement-Test Execution Unit

This block is one integer execution slice of a 32-bit RISC core. Each cycle it decodes a 16-bit instruction word and, from the source operand, the destination operand and the current condition flag, computes the destination write value, the new condition flag, and the two write enables that the register file and the flag register use. It covers seven operations: decrement with zero test, sign extension and zero extension of the low byte or low halfword, two's-complement negate, and negate with borrow.

The result is computed combinationally from the inputs and registered, so every operation finishes in a single cycle: inputs presented before a rising edge appear on the outputs right after that edge. The register indices in the instruction word are not used here. Register file storage and instruction fetch sit outside the block. Any word that matches none of the seven exact patterns raises an illegal-opcode output and suppresses both writes.

Top module: `xnd_exec_unit`

## Requirements
- R1: Word `0100nnnn00010000` writes the destination value minus 1 (mod 2^32), sets the flag to 1 when that result is zero and to 0 otherwise, and asserts both write enables.
- R2: Word `0110nnnnmmmm1110` writes the low 8 bits of the source with bit 7 copied into bits 31..8.
- R3: Word `0110nnnnmmmm1111` writes the low 16 bits of the source with bit 15 copied into bits 31..16.
- R4: Word `0110nnnnmmmm1100` writes the low 8 bits of the source with bits 31..8 cleared.
- R5: Word `0110nnnnmmmm1101` writes the low 16 bits of the source with bits 31..16 cleared.
- R6: Word `0110nnnnmmmm1011` writes 0 minus the source (mod 2^32) with the register write enable set.
- R7: Word `0110nnnnmmmm1010` writes 0 minus the source minus the flag (mod 2^32), asserts both write enables, and sets the new flag to 1 exactly when the source is nonzero or the incoming flag is 1.
- R8: Any word outside the seven patterns (the nnnn and mmmm nibbles are free, every other bit exact) drives the illegal output to 1 and both write enables to 0; a legal word drives the illegal output to 0.
- R9: Outputs reflect the inputs present at the previous rising clock edge; while reset is low every output is 0.
- R10: For the five operations of R2 to R6, the flag write enable is 0 and the flag output equals the incoming flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 16 | Instruction word |
| src_i | input | 32 | Source register value |
| dst_i | input | 32 | Destination register value |
| flag_i | input | 1 | Current condition flag |
| wdata_o | output | 32 | Destination write value |
| wen_o | output | 1 | Destination write enable |
| flag_o | output | 1 | New condition flag |
| flag_wen_o | output | 1 | Flag write enable |
| illegal_o | output | 1 | Instruction word not recognised |

## Verification
The hardest situations to reach are the negate-with-borrow edges: a source of zero with the flag clear, the only case whose borrow is 0, and an all-ones source with the flag set, where the result wraps to zero while the borrow stays 1; the decrement reaching exactly zero is similarly rare. Uniform random operands almost never land there, so the operand generator draws from a pool of boundary values (0, 1, all ones, sign-bit edges of byte, halfword and word) half the time, and directed steps hit each edge explicitly. Near-miss instruction words that differ from a legal pattern in one fixed bit are also generated on purpose to exercise the exact decode.

// File: rtl/xnd_pkg.sv
package xnd_pkg;

    typedef enum logic [2:0] {
        OP_DECT = 3'd0,
        OP_SXB  = 3'd1,
        OP_SXW  = 3'd2,
        OP_ZXB  = 3'd3,
        OP_ZXW  = 3'd4,
        OP_NEG  = 3'd5,
        OP_NEGB = 3'd6,
        OP_BAD  = 3'd7
    } xnd_op_e;

    localparam logic [3:0] GRP_DECT = 4'h4;
    localparam logic [3:0] GRP_XN   = 4'h6;
    localparam logic [7:0] DECT_LOW = 8'h10;

    localparam logic [3:0] SUB_SXB  = 4'hE;
    localparam logic [3:0] SUB_SXW  = 4'hF;
    localparam logic [3:0] SUB_ZXB  = 4'hC;
    localparam logic [3:0] SUB_ZXW  = 4'hD;
    localparam logic [3:0] SUB_NEG  = 4'hB;
    localparam logic [3:0] SUB_NEGB = 4'hA;

endpackage

// File: rtl/xnd_decode.sv
module xnd_decode
    import xnd_pkg::*;
#(
    parameter int ILEN = 16
) (
    input  logic [ILEN-1:0] insn,
    output xnd_op_e         op,
    output logic            legal
);
    localparam int GRP_LSB = ILEN - 4;
    localparam int LOW_W   = 8;
    localparam int SUB_W   = 4;

    logic [3:0]       grp;
    logic [LOW_W-1:0] low;
    logic [SUB_W-1:0] sub;

    always_comb begin
        grp = insn[ILEN-1:GRP_LSB];
        low = insn[LOW_W-1:0];
        sub = insn[SUB_W-1:0];
        op  = OP_BAD;
        if (grp == GRP_DECT && low == DECT_LOW) begin
            op = OP_DECT;
        end else if (grp == GRP_XN) begin
            case (sub)
                SUB_SXB:  op = OP_SXB;
                SUB_SXW:  op = OP_SXW;
                SUB_ZXB:  op = OP_ZXB;
                SUB_ZXW:  op = OP_ZXW;
                SUB_NEG:  op = OP_NEG;
                SUB_NEGB: op = OP_NEGB;
                default:  op = OP_BAD;
            endcase
        end
        legal = (op != OP_BAD);
    end

    always_comb begin
        assert_dec_exact_R8: assert (!legal || grp == GRP_DECT || grp == GRP_XN);
    end

endmodule

// File: rtl/xnd_extend.sv
module xnd_extend #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] sx_byte,
    output logic [XLEN-1:0] sx_half,
    output logic [XLEN-1:0] zx_byte,
    output logic [XLEN-1:0] zx_half
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int BYTE_PAD = XLEN - BYTE_W;
    localparam int HALF_PAD = XLEN - HALF_W;

    always_comb begin
        sx_byte = {{BYTE_PAD{src[BYTE_W-1]}}, src[BYTE_W-1:0]};
        sx_half = {{HALF_PAD{src[HALF_W-1]}}, src[HALF_W-1:0]};
        zx_byte = {{BYTE_PAD{1'b0}}, src[BYTE_W-1:0]};
        zx_half = {{HALF_PAD{1'b0}}, src[HALF_W-1:0]};
    end

    always_comb begin
        assert_zx_low_R4: assert (zx_byte[BYTE_W-1:0] == sx_byte[BYTE_W-1:0]);
        assert_zx_low_R5: assert (zx_half[HALF_W-1:0] == sx_half[HALF_W-1:0]);
    end

endmodule

// File: rtl/xnd_arith.sv
module xnd_arith #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    input  logic            flag,
    output logic [XLEN-1:0] dec_val,
    output logic            dec_zero,
    output logic [XLEN-1:0] neg_val,
    output logic [XLEN-1:0] negb_val,
    output logic            negb_borrow
);
    localparam int EXT_W = XLEN + 1;

    logic [EXT_W-1:0] diff;

    always_comb begin
        dec_val     = dst - {{(XLEN-1){1'b0}}, 1'b1};
        dec_zero    = (dec_val == '0);
        neg_val     = '0 - src;
        diff        = {EXT_W{1'b0}} - {1'b0, src} - {{XLEN{1'b0}}, flag};
        negb_val    = diff[XLEN-1:0];
        negb_borrow = diff[XLEN];
    end

    always_comb begin
        assert_borrow_src_R7: assert (!(src != '0) || negb_borrow);
        assert_neg_sum_R6: assert (neg_val + src == '0);
    end

endmodule

// File: rtl/xnd_exec_unit.sv
module xnd_exec_unit
    import xnd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ILEN-1:0] insn_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [XLEN-1:0] dst_i,
    input  logic            flag_i,
    output logic [XLEN-1:0] wdata_o,
    output logic            wen_o,
    output logic            flag_o,
    output logic            flag_wen_o,
    output logic            illegal_o
);
    typedef struct packed {
        logic [XLEN-1:0] wdata;
        logic            wen;
        logic            flag;
        logic            flag_wen;
        logic            illegal;
    } out_s;

    xnd_op_e         op;
    logic            legal;
    logic [XLEN-1:0] sx_byte, sx_half, zx_byte, zx_half;
    logic [XLEN-1:0] dec_val, neg_val, negb_val;
    logic            dec_zero, negb_borrow;
    out_s            state_d, state_q;

    xnd_decode #(.ILEN(ILEN)) u_decode (
        .insn  (insn_i),
        .op    (op),
        .legal (legal)
    );

    xnd_extend #(.XLEN(XLEN)) u_extend (
        .src     (src_i),
        .sx_byte (sx_byte),
        .sx_half (sx_half),
        .zx_byte (zx_byte),
        .zx_half (zx_half)
    );

    xnd_arith #(.XLEN(XLEN)) u_arith (
        .src         (src_i),
        .dst         (dst_i),
        .flag        (flag_i),
        .dec_val     (dec_val),
        .dec_zero    (dec_zero),
        .neg_val     (neg_val),
        .negb_val    (negb_val),
        .negb_borrow (negb_borrow)
    );

    always_comb begin
        state_d          = '0;
        state_d.flag     = flag_i;
        state_d.wen      = legal;
        state_d.illegal  = !legal;
        case (op)
            OP_DECT: begin
                state_d.wdata    = dec_val;
                state_d.flag     = dec_zero;
                state_d.flag_wen = 1'b1;
            end
            OP_SXB:  state_d.wdata = sx_byte;
            OP_SXW:  state_d.wdata = sx_half;
            OP_ZXB:  state_d.wdata = zx_byte;
            OP_ZXW:  state_d.wdata = zx_half;
            OP_NEG:  state_d.wdata = neg_val;
            OP_NEGB: begin
                state_d.wdata    = negb_val;
                state_d.flag     = negb_borrow;
                state_d.flag_wen = 1'b1;
            end
            default: begin
                state_d.wdata = '0;
                state_d.wen   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wdata_o    = state_q.wdata;
    assign wen_o      = state_q.wen;
    assign flag_o     = state_q.flag;
    assign flag_wen_o = state_q.flag_wen;
    assign illegal_o  = state_q.illegal;

    assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wen_o && !flag_wen_o));

    assert_flag_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wen_o |-> wen_o);

    assert_dect_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_DECT) |-> (flag_o == (wdata_o == '0)));

    assert_neg_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_NEG) |-> (wdata_o == '0 - $past(src_i) && !flag_wen_o));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !flag_wen_o) |-> (flag_o == $past(flag_i)));

    assert_sxb_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_SXB) |-> (wdata_o == {{(XLEN-8){$past(src_i[7])}}, $past(src_i[7:0])}));

endmodule

// File: tb/xnd_exec_unit_test.sv
module xnd_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] insn_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic        flag_i = 1'b0;
    logic [31:0] wdata_o;
    logic        wen_o, flag_o, flag_wen_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xnd_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .src_i(src_i), .dst_i(dst_i),
        .flag_i(flag_i), .wdata_o(wdata_o), .wen_o(wen_o), .flag_o(flag_o),
        .flag_wen_o(flag_wen_o), .illegal_o(illegal_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:12] == 4'h4 && w[7:0] == 8'h10) return "R1";
        if (w[15:12] == 4'h6) begin
            case (w[3:0])
                4'hE: return "R2";
                4'hF: return "R3";
                4'hC: return "R4";
                4'hD: return "R5";
                4'hB: return "R6";
                4'hA: return "R7";
                default: return "R8";
            endcase
        end
        return "R8";
    endfunction

    task automatic model(input logic [15:0] w, input logic [31:0] s, input logic [31:0] d, input logic f,
                         output logic [31:0] ev, output logic ewe, output logic ef, output logic efwe, output logic eill);
        string t;
        t = tag_of(w);
        ev = 32'h0; ewe = 1'b1; ef = f; efwe = 1'b0; eill = 1'b0;
        if (t == "R1") begin ev = d - 32'd1; ef = (d == 32'd1); efwe = 1'b1; end
        else if (t == "R2") ev = s[7] ? (32'hFFFFFF00 | {24'h0, s[7:0]}) : {24'h0, s[7:0]};
        else if (t == "R3") ev = s[15] ? (32'hFFFF0000 | {16'h0, s[15:0]}) : {16'h0, s[15:0]};
        else if (t == "R4") ev = s & 32'h000000FF;
        else if (t == "R5") ev = s & 32'h0000FFFF;
        else if (t == "R6") ev = ~s + 32'd1;
        else if (t == "R7") begin ev = ~s + 32'd1 - {31'h0, f}; ef = (s != 32'h0) || f; efwe = 1'b1; end
        else begin ewe = 1'b0; eill = 1'b1; end
    endtask

    task automatic step(input logic [15:0] w, input logic [31:0] s, input logic [31:0] d, input logic f);
        logic [31:0] ev;
        logic ewe, ef, efwe, eill;
        string t;
        model(w, s, d, f, ev, ewe, ef, efwe, eill);
        t = tag_of(w);
        insn_i = w; src_i = s; dst_i = d; flag_i = f;
        @(negedge clk);
        if (ewe) check(t, "wdata", wdata_o, ev);
        check(t, "wen", {31'h0, wen_o}, {31'h0, ewe});
        check(t, "illegal", {31'h0, illegal_o}, {31'h0, eill});
        if (t == "R1" || t == "R7") begin
            check(t, "flag", {31'h0, flag_o}, {31'h0, ef});
            check(t, "flag_wen", {31'h0, flag_wen_o}, {31'h0, efwe});
        end else begin
            check(t == "R8" ? "R8" : "R10", "flag_wen", {31'h0, flag_wen_o}, {31'h0, efwe});
            if (t != "R8") check("R10", "flag", {31'h0, flag_o}, {31'h0, ef});
        end
    endtask

    function automatic logic [31:0] pick_val();
        logic [31:0] pool [8];
        pool[0] = 32'h0; pool[1] = 32'h1; pool[2] = 32'hFFFFFFFF; pool[3] = 32'h80;
        pool[4] = 32'h7F; pool[5] = 32'h8000; pool[6] = 32'h7FFF; pool[7] = 32'h80000000;
        if ($urandom % 2 == 0) return pool[$urandom % 8];
        return $urandom;
    endfunction

    function automatic logic [15:0] pick_insn();
        logic [3:0] subs [6];
        int k;
        subs[0] = 4'hE; subs[1] = 4'hF; subs[2] = 4'hC; subs[3] = 4'hD; subs[4] = 4'hB; subs[5] = 4'hA;
        k = $urandom % 10;
        if (k == 0) return {4'h4, 4'($urandom), 8'h10};
        if (k <= 6) return {4'h6, 8'($urandom), subs[$urandom % 6]};
        if (k == 7) return {4'h4, 4'($urandom), 8'h10 ^ (8'h1 << ($urandom % 8))};
        if (k == 8) return {4'h6 ^ (4'h1 << ($urandom % 4)), 8'($urandom), subs[$urandom % 6]};
        return 16'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        insn_i = 16'h6A5E; src_i = 32'h12345678; flag_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "reset wdata", wdata_o, 32'h0);
        check("R9", "reset wen", {31'h0, wen_o}, 32'h0);
        check("R9", "reset flag", {31'h0, flag_o}, 32'h0);
        check("R9", "reset flag_wen", {31'h0, flag_wen_o}, 32'h0);
        check("R9", "reset illegal", {31'h0, illegal_o}, 32'h0);
        rst_n = 1'b1;

        step(16'h4310, 32'h5, 32'h1, 1'b0);          // R1 reaches zero
        step(16'h4310, 32'h5, 32'h0, 1'b1);          // R1 wraps to all ones
        step(16'h6A1E, 32'h00000080, 32'h0, 1'b0);   // R2 negative byte
        step(16'h6A1F, 32'hABCD7FFF, 32'h0, 1'b1);   // R3 positive word
        step(16'h6A1C, 32'hFFFFFF80, 32'h0, 1'b0);   // R4
        step(16'h6A1D, 32'hFFFF8000, 32'h0, 1'b1);   // R5
        step(16'h6A1B, 32'h80000000, 32'h0, 1'b0);   // R6 most negative
        step(16'h6A1A, 32'h0, 32'h0, 1'b0);          // R7 no borrow
        step(16'h6A1A, 32'h0, 32'h0, 1'b1);          // R7 borrow from flag only
        step(16'h6A1A, 32'hFFFFFFFF, 32'h0, 1'b1);   // R7 wraps to zero with borrow
        step(16'h4311, 32'h0, 32'h7, 1'b1);          // R8 near miss
        step(16'h6A19, 32'h0, 32'h7, 1'b0);          // R8 unused sub code
        step(16'h6A1B, 32'h1, 32'h0, 1'b1);          // R9 back-to-back after illegal

        for (int i = 0; i < 3000; i++) begin
            step(pick_insn(), pick_val(), pick_val(), 1'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule